// File: doc/BRIEF.md
# Test Clock Generator with Gating and Divide-Down

This block makes the serial test clock for a boundary-scan bus master out of the system clock. It has three modes. In free-running mode the test clock toggles all the time. In gated mode it runs only while the sequencer asks for state-move, scan or run-test cycles. In discrete mode the host sets each clock level with a write. In the two counting modes a programmable ratio stretches each clock phase, so a slow target chain can be served from a fast system clock.

With each test-clock edge the block also sends out a one-cycle enable strobe. Neighbouring logic samples returned serial data on the rising strobe. It updates outgoing serial data and mode-select on the falling strobe. The gate opens and closes only while the clock is low, and a low phase is never cut short, so the bus never sees a runt pulse. The sequencer keeps its request high for as long as it wants cycles and lowers it after the falling strobe of the last cycle it needs.

Top module: `tck_gen`

## Requirements
- R1: While reset is asserted, the test clock is low and both strobes are low.
- R2: In free-running mode (mode code 2'b00), the test clock toggles without stopping. Each high phase and each low phase lasts exactly divRatio+1 system-clock cycles.
- R3: The 8-bit ratio value v sets a phase length of v+1 cycles. Value 0 gives 1 cycle per phase, and value 255 gives 256 cycles per phase.
- R4: In gated mode (mode code 2'b01), while cycReq is low and the test clock is low, the test clock stays low and neither strobe fires.
- R5: In gated mode, when cycReq rises while the clock idles low, the first rising edge follows after a full low phase. The clock is high in the divRatio+1-th cycle after the cycle in which the request is first seen.
- R6: In gated mode, if cycReq falls during a high phase, that high phase still lasts its full divRatio+1 cycles. The clock then goes low and stays low.
- R7: In discrete mode (mode code 2'b10), the test clock changes only when discWr is high, and it takes the level on discLvl. A write of the level the clock already has gives no strobe. In the other modes, discWr has no effect.
- R8: riseStb is high for exactly the first system-clock cycle in which the test clock is high. fallStb is high for exactly the first cycle in which it is low. Neither strobe is high at any other time.
- R9: Mode code 2'b11 behaves the same as gated mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Clock mode: 00 free-running, 01 and 11 gated, 10 discrete |
| divRatio | input | 8 | Phase length minus one, in system-clock cycles |
| cycReq | input | 1 | Sequencer request for test-clock cycles (gated mode) |
| discWr | input | 1 | Host write strobe for the clock level (discrete mode) |
| discLvl | input | 1 | Clock level written by the host (discrete mode) |
| tck | output | 1 | Test clock |
| riseStb | output | 1 | One-cycle strobe on the first cycle after a rising test-clock edge |
| fallStb | output | 1 | One-cycle strobe on the first cycle after a falling test-clock edge |

## Verification
Free-running mode is tried with the smallest ratio, a middle ratio and the largest ratio. Measured phase widths of 1, 4 and 256 cycles separate an off-by-one in the ratio decode from a counter that wraps early. Gated mode is tried with the request held low, with the request raised while the clock idles, and with the request dropped during a high phase. These show that nothing leaks through while idle, that the first low phase is full length, and that a closing gate does not cut the last high phase. Discrete writes alternate between new levels and repeated levels, and writes are also made in gated mode. This tells real edges apart from spurious strobes and from writes that should be ignored.

// File: rtl/tck_pkg.sv
package tck_pkg;

  typedef enum logic [1:0] {
    MODE_FREE      = 2'b00,
    MODE_GATED     = 2'b01,
    MODE_DISC      = 2'b10,
    MODE_GATED_ALT = 2'b11
  } tckMode_t;

  typedef struct packed {
    logic goHigh;
    logic goLow;
  } tckCmd_t;

endpackage

// File: rtl/tck_ctrl.sv
module tck_ctrl
  import tck_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             cycReq,
  input  logic             discWr,
  input  logic             discLvl,
  input  logic             tckNow,
  output tckCmd_t          cmd
);

  tckMode_t         mode;
  logic [DIV_W-1:0] phaseCnt;
  logic             isDisc;
  logic             isGated;
  logic             running;
  logic             phaseEnd;

  assign mode = tckMode_t'(modeSel);

  always_comb begin
    isDisc  = (mode == MODE_DISC);
    isGated = (mode == MODE_GATED) || (mode == MODE_GATED_ALT);
    // a gated clock that is high always finishes its phase
    running  = !isDisc && (!isGated || cycReq || tckNow);
    phaseEnd = running && (phaseCnt >= divRatio);
  end

  always_comb begin
    if (isDisc) begin
      cmd.goHigh = discWr && discLvl && !tckNow;
      cmd.goLow  = discWr && !discLvl && tckNow;
    end else begin
      cmd.goHigh = phaseEnd && !tckNow;
      cmd.goLow  = phaseEnd && tckNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (!running || phaseEnd) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

endmodule

// File: rtl/tck_dp.sv
module tck_dp
  import tck_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  tckCmd_t cmd,
  output logic    tck,
  output logic    riseStb,
  output logic    fallStb
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tck     <= 1'b0;
      riseStb <= 1'b0;
      fallStb <= 1'b0;
    end else begin
      if (cmd.goHigh) begin
        tck <= 1'b1;
      end else if (cmd.goLow) begin
        tck <= 1'b0;
      end
      riseStb <= cmd.goHigh;
      fallStb <= cmd.goLow;
    end
  end

endmodule

// File: rtl/tck_gen.sv
module tck_gen
  import tck_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             cycReq,
  input  logic             discWr,
  input  logic             discLvl,
  output logic             tck,
  output logic             riseStb,
  output logic             fallStb
);

  tckCmd_t cmd;

  tck_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .divRatio(divRatio),
    .cycReq  (cycReq),
    .discWr  (discWr),
    .discLvl (discLvl),
    .tckNow  (tck),
    .cmd     (cmd)
  );

  tck_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .tck    (tck),
    .riseStb(riseStb),
    .fallStb(fallStb)
  );

endmodule

// File: rtl/tck_gen_chk.sv
module tck_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic [DIV_W-1:0] divRatio,
  input logic             cycReq,
  input logic             discWr,
  input logic             discLvl,
  input logic             tck,
  input logic             riseStb,
  input logic             fallStb
);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!tck && !riseStb && !fallStb);
    end
  end

  assert_rise_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    riseStb == $rose(tck));

  assert_fall_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    fallStb == $fell(tck));

  assert_gated_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[0] && !cycReq && !tck) |=> !tck);

  assert_disc_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10 && !discWr) |=> $stable(tck));

  assert_disc_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10 && discWr) |=> (tck == $past(discLvl)));

endmodule

bind tck_gen tck_gen_chk #(.DIV_W(DIV_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .modeSel (modeSel),
  .divRatio(divRatio),
  .cycReq  (cycReq),
  .discWr  (discWr),
  .discLvl (discLvl),
  .tck     (tck),
  .riseStb (riseStb),
  .fallStb (fallStb)
);

// File: tb/sim_tck_gen.sv
`timescale 1ns/1ps
module sim_tck_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [7:0] divRatio = 8'd0;
  logic       cycReq = 1'b0;
  logic       discWr = 1'b0;
  logic       discLvl = 1'b0;
  logic       tck;
  logic       riseStb;
  logic       fallStb;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tck_gen u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .divRatio(divRatio),
    .cycReq(cycReq), .discWr(discWr), .discLvl(discLvl),
    .tck(tck), .riseStb(riseStb), .fallStb(fallStb)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Starts on the first sample of a phase and ends on the first sample of the next one.
  task automatic measurePhase(output int width, output int stbErr);
    logic lvl;
    lvl = tck;
    width = 0;
    stbErr = 0;
    while (tck == lvl && width < 1000) begin
      width++;
      if (width == 1) begin
        if (lvl && (!riseStb || fallStb)) stbErr++;
        if (!lvl && (!fallStb || riseStb)) stbErr++;
      end else if (riseStb || fallStb) begin
        stbErr++;
      end
      @(negedge clk);
    end
  endtask

  task automatic syncRise();
    logic prev;
    prev = tck;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (tck && !prev) return;
      prev = tck;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!tck, "R1 tck in reset", tck, 0);
    check(!riseStb && !fallStb, "R1 strobes in reset", riseStb | fallStb, 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testFree(input int d, input string tag);
    int wHi, wLo, e1, e2;
    modeSel = 2'b00;
    divRatio = 8'(d);
    syncRise();
    measurePhase(wHi, e1);
    measurePhase(wLo, e2);
    check(wHi == d + 1, {tag, " high width"}, wHi, d + 1);
    check(wLo == d + 1, {tag, " low width"}, wLo, d + 1);
    check(e1 + e2 == 0, "R8 strobe placement", e1 + e2, 0);
  endtask

  task automatic goIdle(input logic [1:0] m);
    modeSel = m;
    cycReq = 1'b0;
    for (int i = 0; i < 600 && tck; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testGatedIdle(input logic [1:0] m, input string tag);
    int highs, stbs;
    goIdle(m);
    highs = 0;
    stbs = 0;
    for (int i = 0; i < 40; i++) begin
      discWr = (i % 3 == 0);
      discLvl = 1'b1;
      @(negedge clk);
      if (tck) highs++;
      if (riseStb || fallStb) stbs++;
    end
    discWr = 1'b0;
    check(highs == 0, {tag, " clock stays low"}, highs, 0);
    check(stbs == 0, {tag, " no strobes"}, stbs, 0);
  endtask

  task automatic testGatedOpenClose(input int d);
    int k, w, e, highs;
    divRatio = 8'(d);
    goIdle(2'b01);
    cycReq = 1'b1;
    k = 0;
    for (int i = 0; i < 600 && !tck; i++) begin
      @(negedge clk);
      k++;
    end
    check(k == d + 1, "R5 first rise delay", k, d + 1);
    check(riseStb, "R8 rise strobe on open", riseStb, 1);
    cycReq = 1'b0;
    measurePhase(w, e);
    check(w == d + 1, "R6 last high phase full", w, d + 1);
    check(e == 0, "R8 strobes on close", e, 0);
    highs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tck) highs++;
    end
    check(highs == 0, "R6 clock stays low after close", highs, 0);
  endtask

  task automatic discWrite(input logic lvl);
    discWr = 1'b1;
    discLvl = lvl;
    @(negedge clk);
    discWr = 1'b0;
  endtask

  task automatic testDiscrete();
    int moves;
    goIdle(2'b01);
    modeSel = 2'b10;
    moves = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tck || riseStb || fallStb) moves++;
    end
    check(moves == 0, "R7 no change without write", moves, 0);
    discWrite(1'b1);
    check(tck && riseStb, "R7 write high", {tck, riseStb}, 3);
    @(negedge clk);
    check(tck && !riseStb, "R8 rise strobe one cycle", {tck, riseStb}, 2);
    discWrite(1'b1);
    check(tck && !riseStb, "R7 repeat high no strobe", {tck, riseStb}, 2);
    discWrite(1'b0);
    check(!tck && fallStb, "R7 write low", {tck, fallStb}, 1);
    discWrite(1'b0);
    check(!tck && !fallStb, "R7 repeat low no strobe", {tck, fallStb}, 0);
  endtask

  initial begin
    testReset();
    testFree(3, "R2");
    testFree(0, "R3 min ratio");
    testFree(255, "R3 max ratio");
    testGatedIdle(2'b01, "R4");
    testGatedIdle(2'b11, "R9");
    testGatedOpenClose(4);
    testGatedOpenClose(0);
    testDiscrete();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule